// File: doc/BRIEF.md
# Watchdog Timer with Register Port

This block is a countdown supervisor for a system that must prove it is still alive. Software writes a 16-bit timeout, counted in ticks, into a count register. A write to the control word starts the countdown. The same write can also carry a self-clearing reload strobe that copies the timeout into the down-counter. While the countdown runs, software has to repeat the reload before the count reaches zero.

If the count runs out, the block does three things:
- It sets a fired flag, which software clears by writing a one to it.
- It drives either a reset pulse or a shutdown pulse for a fixed number of clock cycles. A control bit picks which one.
- If the action was reset, it sets a cause flag. This flag is clocked on a separate power-on reset, so it survives the reset the watchdog itself requests.

The tick comes from a prescaler on the fast reference clock. Two select pins choose one of four tick periods. A global enable pin gates the whole timer. A hardware disable strap keeps the run bit cleared and shows up as a read-only status bit.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the control word and the count register read 0x0, and `rst_o`, `shut_o` and `cause_o` are low.
- R2: A write to offset 0x04 stores bits 15:0 as the timeout. Reading offset 0x04 returns the timeout in bits 15:0 with zeros above.
- R3: Control bit 3 reads the level of `hw_disable_i`. While that pin is high, the run bit (bit 0) is held at 0 and a write cannot set it.
- R4: Control bits 6:4 and bits 31:8 always read 0. Bit 7, the reload strobe, always reads back 0. Bit 2 (action) and bit 0 (run) read back the last values written.
- R5: A write to offset 0x00 with bit 7 set loads the timeout into the counter and arms it. With run set, fired (control bit 1) becomes 1 exactly max(timeout,1) x P clock cycles after that write, where P is the tick period. Before that cycle it stays 0.
- R6: While the run bit is 0, the counter holds its value. When run is set again without a reload, the countdown resumes from the held value with a fresh prescaler phase.
- R7: `res_sel_i` picks the tick period P as TICK_CYC[res_sel_i] clock cycles. The codes 0 to 3 run from the finest to the coarsest period.
- R8: A change of `res_sel_i` restarts the prescaler phase. The next tick comes a full new period after the change.
- R9: On expiry, `rst_o` goes high for PULSE_CYC cycles when control bit 2 is 0. `shut_o` goes high for PULSE_CYC cycles when bit 2 is 1. The two outputs are never high together.
- R10: Writing 1 to control bit 1 clears fired. Writing 0 to bit 1 leaves it unchanged.
- R11: After expiry, the counter stays stopped until the next reload, even if run stays 1. `cause_o` is set by an expiry whose action is reset, keeps its value through `rst_ni`, and is cleared only by `por_ni`.
- R12: While `wdt_en_i` is low, no tick occurs and the counter holds. Counting resumes when the pin returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset for the cause flag |
| wdt_en_i | input | 1 | Global watchdog enable |
| res_sel_i | input | 2 | Tick period select |
| hw_disable_i | input | 1 | Hardware disable strap |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| rst_o | output | 1 | Reset request pulse |
| shut_o | output | 1 | Shutdown request pulse |
| cause_o | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
A table of expiry vectors varies three things: the tick select, the timeout (0, 1 and several larger values) and the action bit.

- Each vector checks fired one cycle before the predicted expiry and in the predicted cycle. A wrong divider or an off-by-one tick count shows up as a mismatch at one of these two samples.
- The action bit tells the reset and shutdown paths apart.
- Timeout 0 separates the "expire on the first tick" rule from a wrap to 65535.

Directed sequences cover the remaining control paths, each with exact cycle timing:
- pausing with run at 0, then resuming
- a tick select change in mid-period
- dropping the global enable
- the disable strap
- write-one-clear of fired
- staying stopped after expiry
- the cause flag across the two kinds of reset

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned TMO_W   = 16;
  localparam int unsigned OFF_CTRL  = 'h00;
  localparam int unsigned OFF_COUNT = 'h04;
  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_FIRED  = 1;
  localparam int unsigned B_ACT    = 2;
  localparam int unsigned B_DIS    = 3;
  localparam int unsigned B_RELOAD = 7;

  typedef enum logic {ACT_RESET = 1'b0, ACT_SHUT = 1'b1} act_e;
  typedef logic [TMO_W-1:0] tmo_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              hw_disable_i,
  input  logic              expire_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              run_o,
  output act_e              act_o,
  output logic              reload_o,
  output tmo_t              tmo_o
);
  logic sel_ctrl, sel_count, wr_ctrl, wr_count;
  logic run_q, fired_q;
  act_e act_q;
  tmo_t tmo_q;
  logic unused_wdata;

  assign sel_ctrl  = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_count = addr_i == ADDR_W'(OFF_COUNT);
  assign wr_ctrl   = req_i && we_i && sel_ctrl;
  assign wr_count  = req_i && we_i && sel_count;
  assign unused_wdata = ^{wdata_i[REG_W-1:TMO_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      fired_q <= 1'b0;
      act_q   <= ACT_RESET;
      tmo_q   <= '0;
    end else begin
      if (hw_disable_i)  run_q <= 1'b0;
      else if (wr_ctrl)  run_q <= wdata_i[B_RUN];
      // expiry wins over a same-cycle clear
      if (expire_i)                        fired_q <= 1'b1;
      else if (wr_ctrl && wdata_i[B_FIRED]) fired_q <= 1'b0;
      if (wr_ctrl)  act_q <= act_e'(wdata_i[B_ACT]);
      if (wr_count) tmo_q <= wdata_i[TMO_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[B_RUN]   = run_q;
      rdata_o[B_FIRED] = fired_q;
      rdata_o[B_ACT]   = act_q;
      rdata_o[B_DIS]   = hw_disable_i;
    end else if (sel_count) begin
      rdata_o[TMO_W-1:0] = tmo_q;
    end
  end

  assign run_o    = run_q;
  assign act_o    = act_q;
  assign reload_o = wr_ctrl && wdata_i[B_RELOAD];
  assign tmo_o    = tmo_q;

  AST_RUN_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_disable_i |=> !run_q); // R3
  AST_FIRED_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> fired_q); // R5
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_CYC [4] = '{4000, 1250000, 12500000, 125000000}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  function automatic int unsigned max_of(input int unsigned a [4]);
    int unsigned m;
    m = 1;
    for (int i = 0; i < 4; i++) if (a[i] > m) m = a[i];
    return m;
  endfunction

  localparam int unsigned MAX_CYC = max_of(TICK_CYC);
  localparam int unsigned PW = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic [PW-1:0] tc [4];
  logic [PW-1:0] pre_q;
  logic [1:0]    sel_q;
  logic          sel_chg;

  for (genvar g = 0; g < 4; g++) begin : g_tc
    assign tc[g] = PW'(TICK_CYC[g] - 1);
  end

  assign sel_chg = sel_i != sel_q;
  assign tick_o  = en_i && !sel_chg && (pre_q == tc[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (!en_i || sel_chg || tick_o) pre_q <= '0;
      else                            pre_q <= pre_q + 1'b1;
    end
  end

  AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg |=> !tick_o); // R8
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  input  tmo_t tmo_i,
  input  logic tick_i,
  output logic expire_o,
  output logic armed_o,
  output tmo_t cnt_o
);
  tmo_t cnt_q;
  logic armed_q;
  logic last;

  assign last     = cnt_q <= tmo_t'(1);
  assign expire_o = tick_i && last && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (reload_i) begin
      cnt_q   <= tmo_i;
      armed_q <= 1'b1;
    end else if (tick_i) begin
      if (last) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
  assign cnt_o   = cnt_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reload_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned TICK_CYC [4] = '{4000, 1250000, 12500000, 125000000},
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wdt_en_i,
  input  logic [1:0]        res_sel_i,
  input  logic              hw_disable_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rst_o,
  output logic              shut_o,
  output logic              cause_o
);
  localparam int unsigned PCW = $clog2(PULSE_CYC + 1);

  logic run, reload, tick, expire, armed, active;
  act_e act, act_lat_q;
  tmo_t tmo, cnt;
  logic [PCW-1:0] pcnt_q;
  logic cause_q;

  wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .hw_disable_i,
    .expire_i(expire), .rdata_o, .run_o(run), .act_o(act),
    .reload_o(reload), .tmo_o(tmo)
  );

  assign active = wdt_en_i && run && armed;

  wdt_prescaler #(.TICK_CYC(TICK_CYC)) u_pre (
    .clk_i, .rst_ni, .en_i(active), .sel_i(res_sel_i), .tick_o(tick)
  );

  wdt_counter u_cnt (
    .clk_i, .rst_ni, .reload_i(reload), .tmo_i(tmo), .tick_i(tick),
    .expire_o(expire), .armed_o(armed), .cnt_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q    <= '0;
      act_lat_q <= ACT_RESET;
    end else if (expire) begin
      pcnt_q    <= PCW'(PULSE_CYC);
      act_lat_q <= act;
    end else if (pcnt_q != '0) begin
      pcnt_q <= pcnt_q - 1'b1;
    end
  end

  // cause flag lives in the power-on domain so the watchdog reset keeps it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                           cause_q <= 1'b0;
    else if (expire && act == ACT_RESET)   cause_q <= 1'b1;
  end

  assign rst_o   = (pcnt_q != '0) && act_lat_q == ACT_RESET;
  assign shut_o  = (pcnt_q != '0) && act_lat_q == ACT_SHUT;
  assign cause_o = cause_q;

  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_o, shut_o})); // R9
  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
    cause_q |=> cause_q); // R11
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdt_en_i && !reload) |=> $stable(cnt)); // R12
endmodule

// File: tb/wdt_timer_tb_top.sv
`timescale 1ns/1ps
module wdt_timer_tb_top;
  localparam int unsigned CYC [4] = '{2, 3, 5, 7};
  localparam int unsigned PULSE = 4;
  localparam int NV = 6;
  // {act, res_sel, timeout}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'd1}, {1'b1, 2'd1, 16'd3}, {1'b0, 2'd2, 16'd2},
    {1'b1, 2'd3, 16'd1}, {1'b0, 2'd0, 16'd0}, {1'b0, 2'd1, 16'd5}};

  logic clk = 0, rst_n = 0, por_n = 0, en = 1, hw_dis = 0;
  logic [1:0] res = 0;
  logic req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic rst_o, shut_o, cause_o;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  wdt_timer #(.ADDR_W(8), .TICK_CYC(CYC), .PULSE_CYC(PULSE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .wdt_en_i(en),
    .res_sel_i(res), .hw_disable_i(hw_dis), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_o(rst_o),
    .shut_o(shut_o), .cause_o(cause_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1; por_n = 1;
    step(1);
    // R1 reset state
    rdr(8'h00, rd); chk("R1 ctrl", rd, 0);
    rdr(8'h04, rd); chk("R1 count", rd, 0);
    chk("R1 outs", {rst_o, shut_o, cause_o}, 0);

    // R2 count width
    wr(8'h04, 32'hFFFF_ABCD);
    rdr(8'h04, rd); chk("R2 count", rd, 32'h0000_ABCD);

    // R4 reserved and strobe read zero
    wr(8'h00, 32'hFFFF_FFF5);
    rdr(8'h00, rd); chk("R4 ctrl", rd, 32'h5);
    wr(8'h00, 32'h2);

    // R3 disable strap
    hw_dis = 1;
    wr(8'h00, 32'h1);
    rdr(8'h00, rd); chk("R3 blocked", rd, 32'h8);
    hw_dis = 0;
    step(1);
    rdr(8'h00, rd); chk("R3 released", rd, 32'h0);

    // R5 R7 R9 table
    for (int v = 0; v < NV; v++) begin
      automatic logic act = VEC[v][18];
      automatic logic [1:0] rs = VEC[v][17:16];
      automatic int tmo = VEC[v][15:0];
      automatic int t = ((tmo == 0) ? 1 : tmo) * CYC[rs];
      res = rs;
      wr(8'h04, 32'(tmo));
      wr(8'h00, 32'h2);
      wr(8'h00, 32'h81 | (32'(act) << 2));
      step(t - 1);
      rdr(8'h00, rd); chk("R5 early", 32'(rd[1]), 0);
      step(1);
      rdr(8'h00, rd); chk("R5 R7 fired", 32'(rd[1]), 1);
      chk("R9 pulse", {rst_o, shut_o}, act ? 2'b01 : 2'b10);
      step(PULSE);
      chk("R9 end", {rst_o, shut_o}, 0);
      if (!act) chk("R11 cause", 32'(cause_o), 1);
    end

    // R10 write-one-clear
    wr(8'h00, 32'h0);
    rdr(8'h00, rd); chk("R10 keep", rd, 32'h2);
    wr(8'h00, 32'h2);
    rdr(8'h00, rd); chk("R10 clear", rd, 32'h0);

    // R6 pause and resume
    res = 0;
    wr(8'h04, 32'd3);
    wr(8'h00, 32'h81);
    step(2);
    wr(8'h00, 32'h0);
    step(20);
    rdr(8'h00, rd); chk("R6 held", 32'(rd[1]), 0);
    wr(8'h00, 32'h1);
    step(3);
    rdr(8'h00, rd); chk("R6 early", 32'(rd[1]), 0);
    step(1);
    rdr(8'h00, rd); chk("R6 resumed", 32'(rd[1]), 1);

    // R11 stopped after expiry while run stays set
    wr(8'h00, 32'h3);
    step(30);
    rdr(8'h00, rd); chk("R11 stopped", rd, 32'h1);
    wr(8'h00, 32'h2);

    // R8 resolution change restarts phase
    res = 2;
    wr(8'h04, 32'd1);
    wr(8'h00, 32'h81);
    step(1);
    res = 0;
    step(2);
    rdr(8'h00, rd); chk("R8 early", 32'(rd[1]), 0);
    step(1);
    rdr(8'h00, rd); chk("R8 tick", 32'(rd[1]), 1);
    wr(8'h00, 32'h2);

    // R12 global enable
    en = 0;
    wr(8'h00, 32'h81);
    step(10);
    rdr(8'h00, rd); chk("R12 held", 32'(rd[1]), 0);
    en = 1;
    step(1);
    rdr(8'h00, rd); chk("R12 early", 32'(rd[1]), 0);
    step(1);
    rdr(8'h00, rd); chk("R12 resumed", 32'(rd[1]), 1);

    // R11 cause across resets
    step(PULSE + 1);
    rst_n = 0; step(2); rst_n = 1; step(1);
    chk("R11 after rst", 32'(cause_o), 1);
    rdr(8'h00, rd); chk("R1 ctrl after rst", rd, 0);
    por_n = 0; rst_n = 0; step(2); por_n = 1; rst_n = 1; step(1);
    chk("R11 after por", 32'(cause_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule